// File: doc/BRIEF.md
# Ethernet transmit pad and FCS inserter

This block sits in the transmit path between a byte-wide frame source and the MAC output. Bytes stream through it unchanged and with no added latency. Once the source marks the last byte of a frame, the block can extend the frame. It adds zero bytes until the frame reaches a configured minimum length, and then it adds a 4-byte CRC-32 frame check sequence (FCS). A 3-bit pad mode selects the minimum length. One of the pad modes reads the frame's type field and gives VLAN-tagged frames the longer minimum.

When the block adds no FCS, it treats the last four bytes of each frame as an FCS that is already present. It checks those bytes and reports a mismatch. An optional 4-byte private header can lead each frame. The header is passed through, but it is left out of the CRC, the length count and the type-field position.

Each finished frame produces a one-cycle status pulse. The pulse carries three flags: FCS error, VLAN type seen, and padding inserted.

The controller has three states:
- `ST_PASS` forwards source bytes.
- `ST_PAD` emits zero bytes.
- `ST_FCS` emits the four FCS bytes.

The transitions are:
- `ST_PASS→ST_PAD`: the last source byte is accepted, an FCS is due, and the body is shorter than the minimum.
- `ST_PASS→ST_FCS`: the last source byte is accepted, an FCS is due, and the body has reached the minimum.
- `ST_PAD→ST_FCS`: the last pad byte is accepted.
- `ST_FCS→ST_PASS`: the fourth FCS byte is accepted.

Top module: `frame_pad_fcs`

## Requirements
- R1: Pad modes whose bit 0 is 0 (000, 010, 100, 110) never insert pad bytes. With the FCS-add input set, the frame gets its body followed only by the 4 FCS bytes.
- R2: Pad mode 001 appends zero bytes until the body holds 60 bytes, then appends the FCS. A body of 60 bytes or more gets no pad.
- R3: Pad modes 011 and 111 pad with zeros to a 64-byte body, then append the FCS.
- R4: Pad mode 101 pads to 64 bytes when body bytes 12 and 13 are 81h then 00h. Otherwise it pads to 60 bytes. In both cases the FCS follows.
- R5: An FCS is appended when the FCS-add input is 1 or pad-mode bit 0 is 1. The FCS is the reflected CRC-32 (polynomial 04C11DB7h, register preset to all ones, result inverted) over the body and pad, sent least significant byte first.
- R6: When no FCS is appended, the output equals the input byte for byte. The last four body bytes are checked as an FCS (LSB first), and the status error flag is 1 exactly on a mismatch.
- R7: With the header input set, the first 4 bytes of a frame are forwarded but excluded from the CRC, from the minimum-length count, and from the type-field offset.
- R8: While pad or FCS bytes are being emitted, in_ready is 0. A stalled output (out_ready 0) keeps out_valid high and out_data unchanged.
- R9: out_sof marks only the first output byte of a frame. out_eof marks only the last output byte, which is the final FCS byte when an FCS is appended.
- R10: One cycle after the last output byte is accepted, stat_valid pulses for one cycle. stat_vlan reports a body type field of 8100h, and stat_padded reports that pad bytes were inserted.
- R11: After reset the block is in pass-through: out_valid is 0 with no input, in_ready follows out_ready, and stat_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pad_mode | input | 3 | Pad mode (static per frame) |
| cfg_fcs_add | input | 1 | Force FCS append on every frame |
| cfg_hdr_en | input | 1 | Frames carry a 4-byte private header |
| in_valid | input | 1 | Source byte valid |
| in_ready | output | 1 | Block accepts source byte |
| in_data | input | 8 | Source byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First output byte of frame |
| out_eof | output | 1 | Last output byte of frame |
| stat_valid | output | 1 | Per-frame status pulse |
| stat_fcs_err | output | 1 | Trailing FCS mismatch (check mode) |
| stat_vlan | output | 1 | Type field was 8100h |
| stat_padded | output | 1 | Pad bytes were inserted |

## Verification
The main function is tried with short, exact-minimum and over-minimum bodies, with tagged and untagged type fields, in every pad mode. These patterns separate the 60-byte target from the 64-byte target and separate the padding modes from the non-padding modes. Frames with a good and a corrupted trailing FCS separate the check path from the append path. Header-prefixed frames show whether the CRC, the length count and the type offset skip the header. A run with random output stalls shows whether pad and FCS bytes hold steady and whether in_ready stays low during the tail.

// File: rtl/fpf_pkg.sv
package fpf_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;
    localparam int          FCS_BYTES     = 4;
    localparam int          FIDX_W        = $clog2(FCS_BYTES);

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_PAD  = 2'd1,
        ST_FCS  = 2'd2
    } fpf_state_e;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/fpf_mode_dec.sv
module fpf_mode_dec #(
    parameter int LEN_W     = 16,
    parameter int SHORT_MIN = 60,
    parameter int LONG_MIN  = 64
) (
    input  logic [2:0]       pad_mode,
    input  logic             fcs_add,
    input  logic             is_vlan,
    output logic             append,
    output logic [LEN_W-1:0] min_len
);

    always_comb begin
        append = fcs_add | pad_mode[0];
        unique case (pad_mode)
            3'b001:         min_len = LEN_W'(SHORT_MIN);
            3'b011, 3'b111: min_len = LEN_W'(LONG_MIN);
            3'b101:         min_len = is_vlan ? LEN_W'(LONG_MIN) : LEN_W'(SHORT_MIN);
            default:        min_len = '0;
        endcase
    end

endmodule

// File: rtl/fpf_crc32.sv
module fpf_crc32
    import fpf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [31:0] crc_q,
    output logic [31:0] crc_nx
);

    logic [31:0] base;

    always_comb begin
        base = init ? CRC_PRESET : crc_q;
        if (upd) begin
            crc_nx = crc_step(base, din);
        end else begin
            crc_nx = base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_PRESET;
        end else begin
            crc_q <= crc_nx;
        end
    end

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !upd) |=> (crc_q == $past(crc_q)));  // R5

endmodule

// File: rtl/fpf_fsm.sv
module fpf_fsm
    import fpf_pkg::*;
#(
    parameter int          LEN_W     = 16,
    parameter int          HDR_BYTES = 4,
    parameter int          TYPE_OFS  = 12,
    parameter logic [15:0] VLAN_TPID = 16'h8100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_hdr_en,
    input  logic             append,
    input  logic [LEN_W-1:0] min_len,
    output logic             vlan_nx,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic             crc_init,
    output logic             crc_upd,
    output logic [7:0]       crc_din,
    input  logic [31:0]      crc_q,
    input  logic [31:0]      crc_nx,
    output logic             stat_valid,
    output logic             stat_fcs_err,
    output logic             stat_vlan,
    output logic             stat_padded
);

    localparam int HCNT_W = $clog2(HDR_BYTES + 1);

    fpf_state_e        st, st_nx;
    logic [LEN_W-1:0]  cnt, tgt_q;
    logic [HCNT_W-1:0] hcnt;
    logic [15:0]       type_q;
    logic [FIDX_W-1:0] fidx;
    logic              vlan_q, padded_q;
    logic              sv_q, se_q, sl_q, sp_q;

    logic              acc, in_hdr, fcs_last;
    logic [LEN_W-1:0]  cnt_cur, body_len;
    logic [HCNT_W-1:0] hcnt_cur;
    logic [15:0]       type_cur, type_nx;
    logic [31:0]       fcs_word;

    // Per-byte bookkeeping for the pass-through path
    always_comb begin
        acc      = (st == ST_PASS) && in_valid && out_ready;
        cnt_cur  = in_sof ? '0 : cnt;
        hcnt_cur = in_sof ? '0 : hcnt;
        type_cur = in_sof ? '0 : type_q;
        in_hdr   = cfg_hdr_en && (hcnt_cur < HCNT_W'(HDR_BYTES));
        body_len = cnt_cur + LEN_W'(!in_hdr);
        type_nx  = type_cur;
        if (!in_hdr && cnt_cur == LEN_W'(TYPE_OFS)) begin
            type_nx = {in_data, type_cur[7:0]};
        end else if (!in_hdr && cnt_cur == LEN_W'(TYPE_OFS + 1)) begin
            type_nx = {type_cur[15:8], in_data};
        end
        vlan_nx  = (type_nx == VLAN_TPID);
        fcs_word = ~crc_q;
        fcs_last = (fidx == FIDX_W'(FCS_BYTES - 1));
    end

    // CRC engine control
    always_comb begin
        crc_init = acc && in_sof;
        crc_upd  = (acc && !in_hdr) || ((st == ST_PAD) && out_ready);
        crc_din  = (st == ST_PASS) ? in_data : 8'h00;
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_PASS: if (acc && in_eof && append) begin
                st_nx = (body_len < min_len) ? ST_PAD : ST_FCS;
            end
            ST_PAD:  if (out_ready && (cnt + LEN_W'(1) >= tgt_q)) begin
                st_nx = ST_FCS;
            end
            ST_FCS:  if (out_ready && fcs_last) begin
                st_nx = ST_PASS;
            end
            default: st_nx = ST_PASS;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_PASS;
        end else begin
            st <= st_nx;
        end
    end

    // Stream outputs
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_sof   = 1'b0;
        out_eof   = 1'b0;
        in_ready  = 1'b0;
        unique case (st)
            ST_PASS: begin
                out_valid = in_valid;
                out_data  = in_data;
                out_sof   = in_sof;
                out_eof   = in_eof && !append;
                in_ready  = out_ready;
            end
            ST_PAD: begin
                out_valid = 1'b1;
            end
            ST_FCS: begin
                out_valid = 1'b1;
                out_data  = fcs_word[{fidx, 3'b000} +: 8];
                out_eof   = fcs_last;
            end
            default: ;
        endcase
    end

    // Counters, captured fields and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            hcnt     <= '0;
            type_q   <= '0;
            tgt_q    <= '0;
            fidx     <= '0;
            vlan_q   <= 1'b0;
            padded_q <= 1'b0;
            sv_q     <= 1'b0;
            se_q     <= 1'b0;
            sl_q     <= 1'b0;
            sp_q     <= 1'b0;
        end else begin
            sv_q <= 1'b0;
            unique case (st)
                ST_PASS: if (acc) begin
                    cnt    <= body_len;
                    hcnt   <= in_hdr ? (hcnt_cur + HCNT_W'(1)) : hcnt_cur;
                    type_q <= type_nx;
                    fidx   <= '0;
                    if (in_eof) begin
                        vlan_q   <= vlan_nx;
                        tgt_q    <= min_len;
                        padded_q <= (body_len < min_len);
                        if (!append) begin
                            sv_q <= 1'b1;
                            se_q <= (crc_nx != CRC_RESIDUE);
                            sl_q <= vlan_nx;
                            sp_q <= 1'b0;
                        end
                    end
                end
                ST_PAD: if (out_ready) begin
                    cnt <= cnt + LEN_W'(1);
                end
                ST_FCS: if (out_ready) begin
                    fidx <= fidx + FIDX_W'(1);
                    if (fcs_last) begin
                        sv_q <= 1'b1;
                        se_q <= 1'b0;
                        sl_q <= vlan_q;
                        sp_q <= padded_q;
                    end
                end
                default: ;
            endcase
        end
    end

    assign stat_valid   = sv_q;
    assign stat_fcs_err = se_q;
    assign stat_vlan    = sl_q;
    assign stat_padded  = sp_q;

    AST_TAIL_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_PASS && !out_ready) |=> (out_valid && $stable(out_data)));  // R8

    AST_TAIL_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_eof && append) |=> !in_ready);  // R8

    AST_PAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAD) |-> (cnt < tgt_q));  // R2

    AST_PAD_THEN_FCS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAD) |=> (st != ST_PASS));  // R5

    AST_EOF_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eof) |=> stat_valid);  // R10

endmodule

// File: rtl/frame_pad_fcs.sv
module frame_pad_fcs #(
    parameter int LEN_W     = 16,
    parameter int SHORT_MIN = 60,
    parameter int LONG_MIN  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cfg_pad_mode,
    input  logic       cfg_fcs_add,
    input  logic       cfg_hdr_en,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof,
    output logic       stat_valid,
    output logic       stat_fcs_err,
    output logic       stat_vlan,
    output logic       stat_padded
);

    logic             append, vlan_nx;
    logic [LEN_W-1:0] min_len;
    logic             crc_init, crc_upd;
    logic [7:0]       crc_din;
    logic [31:0]      crc_q, crc_nx;

    fpf_mode_dec #(
        .LEN_W(LEN_W), .SHORT_MIN(SHORT_MIN), .LONG_MIN(LONG_MIN)
    ) u_dec (
        .pad_mode(cfg_pad_mode),
        .fcs_add (cfg_fcs_add),
        .is_vlan (vlan_nx),
        .append  (append),
        .min_len (min_len)
    );

    fpf_crc32 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .upd   (crc_upd),
        .din   (crc_din),
        .crc_q (crc_q),
        .crc_nx(crc_nx)
    );

    fpf_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_hdr_en  (cfg_hdr_en),
        .append      (append),
        .min_len     (min_len),
        .vlan_nx     (vlan_nx),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .in_sof      (in_sof),
        .in_eof      (in_eof),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_sof     (out_sof),
        .out_eof     (out_eof),
        .crc_init    (crc_init),
        .crc_upd     (crc_upd),
        .crc_din     (crc_din),
        .crc_q       (crc_q),
        .crc_nx      (crc_nx),
        .stat_valid  (stat_valid),
        .stat_fcs_err(stat_fcs_err),
        .stat_vlan   (stat_vlan),
        .stat_padded (stat_padded)
    );

endmodule

// File: tb/frame_pad_fcs_test.sv
module frame_pad_fcs_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_pad_mode = 3'b000;
    logic       cfg_fcs_add = 1'b0;
    logic       cfg_hdr_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_sof, out_eof;
    logic       stat_valid, stat_fcs_err, stat_vlan, stat_padded;

    always #5 clk = ~clk;

    frame_pad_fcs uut (.*);

    int    errs = 0;
    int    checks = 0;
    bit    bp_en = 1'b0;
    bit    done = 1'b0;
    logic [10:0] exp_q[$];   // {generated, sof, eof, data}
    string       tag_q[$];
    logic [2:0]  st_q[$];    // {fcs_err, vlan, padded}
    string       stag_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    function automatic logic [31:0] crc_of(input logic [7:0] d[$]);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (d[i]) begin
            for (int k = 0; k < 8; k++) begin
                if ((c[0] ^ d[i][k]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
                else                          c = c >> 1;
            end
        end
        return ~c;
    endfunction

    // Driver: builds a frame, queues the expected output and status, drives input
    task automatic send(input logic [2:0] mode, input bit fadd, input bit hen,
                        input int n, input int seed, input bit vl, input bit bad,
                        input string tag);
        logic [7:0] body[$];
        logic [7:0] tmp[$];
        logic [7:0] ins[$];
        logic [8:0] outs[$];
        logic [31:0] c;
        bit app;
        int tgt;
        for (int i = 0; i < n; i++) body.push_back(8'(seed + i * 7 + 1));
        if (n >= 14) begin
            body[12] = vl ? 8'h81 : 8'h08;
            body[13] = 8'h00;
        end
        app = fadd | mode[0];
        case (mode)
            3'b001:         tgt = 60;
            3'b011, 3'b111: tgt = 64;
            3'b101:         tgt = (n >= 14 && vl) ? 64 : 60;
            default:        tgt = 0;
        endcase
        if (!app && n >= 4) begin
            tmp = body[0:n-5];
            c = crc_of(tmp);
            for (int k = 0; k < 4; k++) body[n-4+k] = c[8*k +: 8];
            if (bad) body[n-1] = body[n-1] ^ 8'h5A;
        end
        if (hen) for (int k = 0; k < 4; k++) ins.push_back(8'hA0 + 8'(k));
        foreach (body[i]) ins.push_back(body[i]);
        foreach (ins[i]) outs.push_back({1'b0, ins[i]});
        if (app) begin
            tmp = body;
            for (int i = n; i < tgt; i++) begin
                tmp.push_back(8'h00);
                outs.push_back({1'b1, 8'h00});
            end
            c = crc_of(tmp);
            for (int k = 0; k < 4; k++) outs.push_back({1'b1, c[8*k +: 8]});
        end
        foreach (outs[i]) begin
            exp_q.push_back({outs[i][8], (i == 0), (i == outs.size() - 1), outs[i][7:0]});
            tag_q.push_back((app && i >= outs.size() - 4) ? "R5" : tag);
        end
        st_q.push_back({(!app && bad), (n >= 14 && vl), (app && n < tgt)});
        stag_q.push_back(tag);
        cfg_pad_mode = mode;
        cfg_fcs_add  = fadd;
        cfg_hdr_en   = hen;
        foreach (ins[i]) begin
            in_valid = 1'b1;
            in_data  = ins[i];
            in_sof   = (i == 0);
            in_eof   = (i == ins.size() - 1);
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
        wait (exp_q.size() == 0 && st_q.size() == 0);
        @(posedge clk);
        #1;
    endtask

    // Output stall pattern
    initial begin
        forever begin
            @(posedge clk);
            #2;
            out_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;
        end
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected output byte", {24'h0, out_data}, 32'h0);
            end else begin
                logic [10:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(out_data == e[7:0], t, "output byte", {24'h0, out_data}, {24'h0, e[7:0]});
                chk({out_sof, out_eof} == e[9:8], "R9", "sof/eof",
                    {30'h0, out_sof, out_eof}, {30'h0, e[9:8]});
                if (e[10]) chk(in_ready == 1'b0, "R8", "in_ready during tail",
                               {31'h0, in_ready}, 32'h0);
            end
        end
        if (rst_n && stat_valid) begin
            if (st_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected status", 32'h1, 32'h0);
            end else begin
                logic [2:0] s;
                string t;
                s = st_q.pop_front();
                t = stag_q.pop_front();
                chk(stat_fcs_err == s[2], "R6", {"fcs error flag ", t}, {31'h0, stat_fcs_err}, {31'h0, s[2]});
                chk(stat_vlan == s[1], "R10", {"vlan flag ", t}, {31'h0, stat_vlan}, {31'h0, s[1]});
                chk(stat_padded == s[0], "R10", {"padded flag ", t}, {31'h0, stat_padded}, {31'h0, s[0]});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual hung expected drained");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(out_valid == 1'b0, "R11", "out_valid after reset", {31'h0, out_valid}, 32'h0);
        chk(stat_valid == 1'b0, "R11", "stat_valid after reset", {31'h0, stat_valid}, 32'h0);
        chk(in_ready == out_ready, "R11", "in_ready follows out_ready", {31'h0, in_ready}, {31'h0, out_ready});
        @(posedge clk);
        #1;
        send(3'b001, 0, 0, 20, 3, 0, 0, "R2");     // short, pad to 60
        send(3'b001, 0, 0, 60, 9, 0, 0, "R2");     // exactly 60: no pad
        send(3'b001, 0, 0, 70, 5, 1, 0, "R2");     // above minimum
        send(3'b011, 0, 0, 30, 11, 0, 0, "R3");    // pad to 64
        send(3'b111, 1, 0, 10, 17, 0, 0, "R3");    // very short, pad to 64
        send(3'b101, 0, 0, 20, 23, 1, 0, "R4");    // VLAN: 64
        send(3'b101, 0, 0, 20, 29, 0, 0, "R4");    // untagged: 60
        send(3'b101, 0, 0, 62, 31, 1, 0, "R4");    // tagged, 62 -> 64
        send(3'b000, 1, 0, 20, 37, 0, 0, "R1");    // no pad, FCS only
        send(3'b100, 1, 0, 10, 41, 1, 0, "R1");
        send(3'b110, 0, 0, 40, 43, 0, 0, "R6");    // check mode, good
        send(3'b010, 0, 0, 40, 47, 1, 1, "R6");    // check mode, bad
        send(3'b101, 0, 1, 20, 53, 1, 0, "R7");    // header + VLAN
        send(3'b000, 0, 1, 30, 59, 0, 0, "R7");    // header, check mode
        send(3'b001, 0, 1, 60, 61, 0, 0, "R7");    // header, body exactly 60
        bp_en = 1'b1;
        send(3'b011, 0, 0, 12, 67, 0, 0, "R8");
        send(3'b101, 1, 1, 25, 71, 1, 0, "R8");
        send(3'b110, 0, 0, 16, 73, 0, 1, "R8");
        send(3'b001, 0, 0, 61, 79, 0, 0, "R8");
        bp_en = 1'b0;
        repeat (5) @(posedge clk);
        done = 1'b1;
        report();
    end

endmodule